// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt requests and decides, for each of several CPU interfaces, which one request that CPU should take next. Shared device lines arrive as level-sensitive inputs. The lowest thirty-two interrupt numbers are private to each CPU, and software raises them through a software-interrupt word. Each source carries an enable bit, an 8-bit urgency value and, for shared sources, a byte of CPU routing bits. For every CPU the block presents the most urgent source that is pending, enabled, routed to that CPU and not already being serviced by it, together with that source's urgency value.

Software reaches the block through a flat word-addressed register port. Each access carries a CPU index beside the address. That index selects which copy of the private state the access sees. Arbitration is done by a sequencer that walks every source number in ascending order, one per cycle, with one comparator per CPU. At the end of each pass the result is published to the outputs.

The sequencer has three states. `SC_IDLE` is the reset state and is held while the global enable is off. `SC_SCAN` evaluates one source per cycle. `SC_PUBLISH` copies each CPU's running winner to its outputs. The transitions are: *start* (`SC_IDLE` to `SC_SCAN` when the enable is on), *last* (`SC_SCAN` to `SC_PUBLISH` at the final source number), *again* (`SC_PUBLISH` to `SC_SCAN` while the enable stays on), and *stop* (`SC_SCAN` or `SC_PUBLISH` to `SC_IDLE` when the enable is off).

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word at address 0x000 enables forwarding, and it resets to 0. While it is 0, every `cpu_irq` bit is low and every CPU shows ID 1023 with urgency 0xFF.
- R2: The read-only word at 0x001 returns NUM_SRC/32-1 in bits 4:0 and zero in all other bits. Writes to it have no effect.
- R3: A write to 0x020+w enables source 32w+b for every bit b written as 1. Bits written as 0 change nothing. The current enable word reads back at both 0x020+w and 0x030+w.
- R4: A write to 0x030+w disables source 32w+b for every bit b written as 1. Bits written as 0 change nothing.
- R5: The word at 0x100+w holds the urgency of source 4w+k in bits 8k+7:8k. A smaller value wins. Among equal values the lower ID wins.
- R6: The word at 0x200+w holds the routing byte of source 4w+k in bits 8k+7:8k, and bit c of that byte routes the source to CPU c. For IDs 0 to 31 this word is read-only and returns, in every byte, only the bit of the accessing CPU.
- R7: For IDs 0 to 31, the enable, pending and active state is held separately per CPU. An access works on the copy selected by `bus_cpu`.
- R8: A write to the software-interrupt word at 0x004 sets ID wdata[3:0] pending in the private state of every CPU c for which wdata[16+c] is 1. CPUs whose bit is 0 are not affected.
- R9: Shared source 32+j is pending while `src_level[j]` is high. The pending state reads at 0x040+w, with word 0 showing the accessing CPU's private copy.
- R10: CPU c's outputs are `cpu_irq[c]`, ID field `cpu_id[10c+9:10c]` and urgency field `cpu_prio[8c+7:8c]`. A valid ID is always below NUM_SRC. When nothing qualifies, the outputs read 0, 1023 and 0xFF.
- R11: Any write to 0x002 marks the ID presented to `bus_cpu` as active for that CPU, and for IDs 0 to 31 it clears that CPU's pending bit. An active source is not presented to that CPU again. Active bits read at 0x050+w.
- R12: A write to 0x003 clears the active bit of ID wdata[9:0] for `bus_cpu` only.
- R13: The outputs are refreshed every NUM_SRC+1 cycles. Any state change becomes visible on them within 2*(NUM_SRC+1)+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_cpu | input | CW | Index of the CPU making the access |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_level | input | NUM_SRC-32 | Level inputs of shared sources 32 and up |
| cpu_irq | output | NUM_CPU | Request present, one bit per CPU |
| cpu_id | output | 10*NUM_CPU | Presented source ID per CPU |
| cpu_prio | output | 8*NUM_CPU | Urgency of the presented source per CPU |

## Verification
The bench programs two sources with the same urgency but different routing, and checks that each CPU picks the lower ID. A design that compared with less-or-equal would pick the higher ID on a tie. A software interrupt is sent to one CPU only, and the bench then reads the private pending word of the other CPU. A design that ignored the target list, or shared the private state between CPUs, would show a stray pending bit there. Acknowledge followed by end-of-interrupt must first hide a source from one CPU only and then bring it back, which catches active state that is not kept per CPU. Clearing the global enable must blank both CPUs even in the middle of a pass, and a write of zeros to the enable words must leave them unchanged.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int AW   = 10;
    localparam int ID_W = 10;

    localparam logic [ID_W-1:0] ID_NONE   = 10'd1023;
    localparam logic [7:0]      PRIO_NONE = 8'hFF;

    // single-word registers
    localparam logic [AW-1:0] A_CTRL  = 10'h000;
    localparam logic [AW-1:0] A_TYPE  = 10'h001;
    localparam logic [AW-1:0] A_ACK   = 10'h002;
    localparam logic [AW-1:0] A_EOI   = 10'h003;
    localparam logic [AW-1:0] A_SWI   = 10'h004;

    // windows of 16 words (32 sources per word)
    localparam logic [AW-1:0] A_ENSET = 10'h020;
    localparam logic [AW-1:0] A_ENCLR = 10'h030;
    localparam logic [AW-1:0] A_PEND  = 10'h040;
    localparam logic [AW-1:0] A_ACTV  = 10'h050;

    // windows of 128 words (4 sources per word)
    localparam logic [AW-1:0] A_PRIO  = 10'h100;
    localparam logic [AW-1:0] A_TGT   = 10'h200;

    typedef enum logic [1:0] {
        SC_IDLE    = 2'd0,
        SC_SCAN    = 2'd1,
        SC_PUBLISH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int NUM_CPU = 2,
    localparam int CW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NW      = NUM_SRC / 32,
    localparam int NPW     = NUM_SRC / 4,
    localparam int NSH     = NUM_SRC - 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_we,
    input  logic [CW-1:0]       bus_cpu,
    output logic [31:0]         bus_rdata,
    input  logic [NSH-1:0]      src_level,
    input  logic                pub_vld [NUM_CPU],
    input  logic [ID_W-1:0]     pub_id  [NUM_CPU],
    output logic                ctl_en,
    output logic [NUM_SRC-1:0]  cand    [NUM_CPU],
    output logic [7:0]          prio_o  [NUM_SRC]
);

    logic               ctl_q;
    logic [31:0]        en_priv  [NUM_CPU];
    logic [31:0]        sgi_pend [NUM_CPU];
    logic [NUM_SRC-1:0] act      [NUM_CPU];
    logic [NSH-1:0]     en_sh;
    logic [7:0]         prio_q   [NUM_SRC];
    logic [7:0]         tgt_q    [NUM_SRC];

    logic [NUM_SRC-1:0] en_full   [NUM_CPU];
    logic [NUM_SRC-1:0] pend_full [NUM_CPU];
    logic [NUM_SRC-1:0] route     [NUM_CPU];

    logic       hit_enset, hit_enclr, hit_pend, hit_actv, hit_prio, hit_tgt;
    logic [3:0] ew;
    logic [6:0] pw;
    logic [7:0] own_bit;

    assign hit_enset = bus_addr[AW-1:4] == A_ENSET[AW-1:4];
    assign hit_enclr = bus_addr[AW-1:4] == A_ENCLR[AW-1:4];
    assign hit_pend  = bus_addr[AW-1:4] == A_PEND[AW-1:4];
    assign hit_actv  = bus_addr[AW-1:4] == A_ACTV[AW-1:4];
    assign hit_prio  = bus_addr[AW-1:7] == A_PRIO[AW-1:7];
    assign hit_tgt   = bus_addr[AW-1:7] == A_TGT[AW-1:7];
    assign ew        = bus_addr[3:0];
    assign pw        = bus_addr[6:0];
    assign own_bit   = 8'd1 << bus_cpu;

    // state update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= 1'b0;
            en_sh <= '0;
            for (int c = 0; c < NUM_CPU; c++) begin
                en_priv[c]  <= '0;
                sgi_pend[c] <= '0;
                act[c]      <= '0;
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                prio_q[i] <= '0;
                tgt_q[i]  <= '0;
            end
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) ctl_q <= bus_wdata[0];

            // private enable words
            for (int c = 0; c < NUM_CPU; c++) begin
                if (bus_cpu == CW'(c) && ew == 4'd0) begin
                    if (hit_enset) en_priv[c] <= en_priv[c] | bus_wdata;
                    if (hit_enclr) en_priv[c] <= en_priv[c] & ~bus_wdata;
                end
            end
            // shared enable words
            for (int w = 1; w < NW; w++) begin
                if (ew == 4'(w)) begin
                    if (hit_enset) en_sh[(w-1)*32 +: 32] <= en_sh[(w-1)*32 +: 32] | bus_wdata;
                    if (hit_enclr) en_sh[(w-1)*32 +: 32] <= en_sh[(w-1)*32 +: 32] & ~bus_wdata;
                end
            end

            for (int w = 0; w < NPW; w++) begin
                if (hit_prio && pw == 7'(w)) begin
                    for (int k = 0; k < 4; k++) prio_q[4*w+k] <= bus_wdata[8*k +: 8];
                end
            end
            for (int w = 8; w < NPW; w++) begin
                if (hit_tgt && pw == 7'(w)) begin
                    for (int k = 0; k < 4; k++) tgt_q[4*w+k] <= bus_wdata[8*k +: 8];
                end
            end

            // software interrupt: set private pending per listed CPU
            if (bus_addr == A_SWI) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (bus_wdata[16+c]) sgi_pend[c][{1'b0, bus_wdata[3:0]}] <= 1'b1;
                end
            end

            // acknowledge: presented ID becomes active for the caller
            if (bus_addr == A_ACK) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (bus_cpu == CW'(c) && pub_vld[c]) begin
                        for (int i = 0; i < NUM_SRC; i++) begin
                            if (pub_id[c] == ID_W'(i)) begin
                                act[c][i] <= 1'b1;
                                if (i < 32) sgi_pend[c][i % 32] <= 1'b0;
                            end
                        end
                    end
                end
            end

            // end of interrupt: release the caller's active bit
            if (bus_addr == A_EOI) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        if (bus_cpu == CW'(c) && bus_wdata[ID_W-1:0] == ID_W'(i))
                            act[c][i] <= 1'b0;
                    end
                end
            end
        end
    end

    // candidate matrix
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            en_full[c]   = {en_sh, en_priv[c]};
            pend_full[c] = {src_level, sgi_pend[c]};
            for (int i = 0; i < NUM_SRC; i++)
                route[c][i] = (i < 32) ? 1'b1 : tgt_q[i][c];
            cand[c] = pend_full[c] & en_full[c] & ~act[c] & route[c];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) prio_o[i] = prio_q[i];
    end

    assign ctl_en = ctl_q;

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) bus_rdata[0] = ctl_q;
        if (bus_addr == A_TYPE) bus_rdata[4:0] = 5'(NW - 1);
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int w = 0; w < NW; w++) begin
                if (bus_cpu == CW'(c) && ew == 4'(w)) begin
                    if (hit_enset || hit_enclr) bus_rdata = en_full[c][w*32 +: 32];
                    if (hit_pend)               bus_rdata = pend_full[c][w*32 +: 32];
                    if (hit_actv)               bus_rdata = act[c][w*32 +: 32];
                end
            end
        end
        for (int w = 0; w < NPW; w++) begin
            if (hit_prio && pw == 7'(w))
                bus_rdata = {prio_q[4*w+3], prio_q[4*w+2], prio_q[4*w+1], prio_q[4*w]};
            if (hit_tgt && pw == 7'(w))
                bus_rdata = (w < 8) ? {4{own_bit}}
                                    : {tgt_q[4*w+3], tgt_q[4*w+2], tgt_q[4*w+1], tgt_q[4*w]};
        end
    end

    // R11: an acknowledge of a presented ID marks it active one cycle later
    a_r11_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ACK && bus_cpu == '0 && pub_vld[0] && pub_id[0] < ID_W'(NUM_SRC))
        |=> act[0][$past(pub_id[0][$clog2(NUM_SRC)-1:0])]);

    // R8: a software write with an empty target list leaves private pending unchanged
    a_r8_no_target_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SWI && bus_wdata[16 +: NUM_CPU] == '0)
        |=> sgi_pend[0] == $past(sgi_pend[0]));

endmodule

// File: rtl/irqd_scan.sv
module irqd_scan
    import irqd_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    localparam int IW      = $clog2(NUM_SRC),
    localparam logic [IW-1:0] LAST = IW'(NUM_SRC - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    output logic [IW-1:0] idx,
    output logic          step,
    output logic          publish,
    output logic          clear
);

    scan_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SC_IDLE:    st_nxt = ctl_en ? SC_SCAN : SC_IDLE;
            SC_SCAN:    st_nxt = !ctl_en ? SC_IDLE : (idx == LAST ? SC_PUBLISH : SC_SCAN);
            SC_PUBLISH: st_nxt = ctl_en ? SC_SCAN : SC_IDLE;
            default:    st_nxt = SC_IDLE;
        endcase
    end

    // state register and source index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SC_IDLE;
            idx <= '0;
        end else begin
            st  <= st_nxt;
            idx <= (st == SC_SCAN && st_nxt == SC_SCAN) ? idx + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        step    = 1'b0;
        publish = 1'b0;
        clear   = !ctl_en;
        unique case (st)
            SC_IDLE:    clear   = 1'b1;
            SC_SCAN:    step    = ctl_en;
            SC_PUBLISH: publish = ctl_en;
            default:    clear   = 1'b1;
        endcase
    end

    // R13: a pass ends with exactly one publish cycle
    a_r13_single_publish: assert property (@(posedge clk) disable iff (!rst_n)
        st == SC_PUBLISH |=> st != SC_PUBLISH);

    // R13: scanning starts from ID 0 after every publish
    a_r13_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SC_PUBLISH && ctl_en) |=> (st == SC_SCAN && idx == '0));

    // R1: the sequencer drops to idle once forwarding is off
    a_r1_stop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> st == SC_IDLE);

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    localparam int IW      = $clog2(NUM_SRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic            publish,
    input  logic [IW-1:0]   idx,
    input  logic            cand_hit,
    input  logic [7:0]      cand_prio,
    output logic            out_vld,
    output logic [ID_W-1:0] out_id,
    output logic [7:0]      out_prio
);

    logic          best_vld;
    logic [IW-1:0] best_id;
    logic [7:0]    best_prio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_vld  <= 1'b0;
            best_id   <= '0;
            best_prio <= PRIO_NONE;
            out_vld   <= 1'b0;
            out_id    <= ID_NONE;
            out_prio  <= PRIO_NONE;
        end else if (clear) begin
            best_vld  <= 1'b0;
            out_vld   <= 1'b0;
            out_id    <= ID_NONE;
            out_prio  <= PRIO_NONE;
        end else begin
            // strict compare: ascending scan keeps the lower ID on a tie
            if (step && cand_hit && (!best_vld || cand_prio < best_prio)) begin
                best_vld  <= 1'b1;
                best_id   <= idx;
                best_prio <= cand_prio;
            end
            if (publish) begin
                out_vld  <= best_vld;
                out_id   <= best_vld ? ID_W'(best_id) : ID_NONE;
                out_prio <= best_vld ? best_prio : PRIO_NONE;
                best_vld <= 1'b0;
            end
        end
    end

    // R10: a presented ID is a real source number
    a_r10_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_id < ID_W'(NUM_SRC));

    // R10: the idle code is presented whenever there is no request
    a_r10_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_id == ID_NONE && out_prio == PRIO_NONE));

    // R5: during a pass the running winner never becomes less urgent
    a_r5_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
        (step && best_vld) |=> (best_vld && best_prio <= $past(best_prio)));

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int NUM_CPU = 2,
    localparam int CW      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IW      = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic                      bus_we,
    input  logic [CW-1:0]             bus_cpu,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_SRC-33:0]       src_level,
    output logic [NUM_CPU-1:0]        cpu_irq,
    output logic [NUM_CPU*ID_W-1:0]   cpu_id,
    output logic [NUM_CPU*8-1:0]      cpu_prio
);

    logic               ctl_en;
    logic [NUM_SRC-1:0] cand   [NUM_CPU];
    logic [7:0]         prio_a [NUM_SRC];
    logic               pub_vld [NUM_CPU];
    logic [ID_W-1:0]    pub_id  [NUM_CPU];
    logic [7:0]         pub_prio[NUM_CPU];
    logic [IW-1:0]      scan_idx;
    logic               step, publish, clear;

    irqd_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_cpu   (bus_cpu),
        .bus_rdata (bus_rdata),
        .src_level (src_level),
        .pub_vld   (pub_vld),
        .pub_id    (pub_id),
        .ctl_en    (ctl_en),
        .cand      (cand),
        .prio_o    (prio_a)
    );

    irqd_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_en  (ctl_en),
        .idx     (scan_idx),
        .step    (step),
        .publish (publish),
        .clear   (clear)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irqd_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear),
            .step      (step),
            .publish   (publish),
            .idx       (scan_idx),
            .cand_hit  (cand[c][scan_idx]),
            .cand_prio (prio_a[scan_idx]),
            .out_vld   (pub_vld[c]),
            .out_id    (pub_id[c]),
            .out_prio  (pub_prio[c])
        );
        assign cpu_irq[c]              = pub_vld[c];
        assign cpu_id[c*ID_W +: ID_W]  = pub_id[c];
        assign cpu_prio[c*8 +: 8]      = pub_prio[c];
    end

    // R1: no CPU sees a request in the cycle after forwarding is off
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> cpu_irq == '0);

endmodule

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;

    localparam int NUM_SRC = 64;
    localparam int NUM_CPU = 2;
    localparam int CW      = 1;
    localparam int WAIT    = 2 * (NUM_SRC + 1) + 2;   // R13 bound

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [9:0]           bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic                 bus_we = 1'b0;
    logic [CW-1:0]        bus_cpu = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_SRC-33:0]  src_level = '0;
    logic [NUM_CPU-1:0]   cpu_irq;
    logic [NUM_CPU*10-1:0] cpu_id;
    logic [NUM_CPU*8-1:0] cpu_prio;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_distributor #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
        .src_level(src_level), .cpu_irq(cpu_irq), .cpu_id(cpu_id), .cpu_prio(cpu_prio)
    );

    typedef struct packed {
        logic        we;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [2:0]  cpu;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h001, 32'h0,        3'd0, 1'b1, 32'h1,        4'd2},  // R2 type
        '{1'b1, 10'h001, 32'hFFFFFFFF, 3'd0, 1'b0, 32'h0,        4'd2},
        '{1'b0, 10'h001, 32'h0,        3'd0, 1'b1, 32'h1,        4'd2},  // R2 write ignored
        '{1'b1, 10'h021, 32'h000000F0, 3'd0, 1'b0, 32'h0,        4'd3},
        '{1'b0, 10'h021, 32'h0,        3'd0, 1'b1, 32'h000000F0, 4'd3},  // R3 set
        '{1'b1, 10'h021, 32'h0,        3'd0, 1'b0, 32'h0,        4'd3},
        '{1'b0, 10'h031, 32'h0,        3'd0, 1'b1, 32'h000000F0, 4'd3},  // R3 zeros, alias
        '{1'b1, 10'h031, 32'h00000030, 3'd0, 1'b0, 32'h0,        4'd4},
        '{1'b0, 10'h021, 32'h0,        3'd0, 1'b1, 32'h000000C0, 4'd4},  // R4 clear
        '{1'b1, 10'h031, 32'h0,        3'd0, 1'b0, 32'h0,        4'd4},
        '{1'b0, 10'h021, 32'h0,        3'd0, 1'b1, 32'h000000C0, 4'd4},  // R4 zeros
        '{1'b1, 10'h020, 32'h00000005, 3'd0, 1'b0, 32'h0,        4'd7},
        '{1'b0, 10'h020, 32'h0,        3'd0, 1'b1, 32'h00000005, 4'd7},  // R7 own copy
        '{1'b0, 10'h020, 32'h0,        3'd1, 1'b1, 32'h00000000, 4'd7},  // R7 other copy
        '{1'b1, 10'h108, 32'h11223344, 3'd0, 1'b0, 32'h0,        4'd5},
        '{1'b0, 10'h108, 32'h0,        3'd0, 1'b1, 32'h11223344, 4'd5},  // R5 lanes
        '{1'b0, 10'h200, 32'h0,        3'd1, 1'b1, 32'h02020202, 4'd6},  // R6 private
        '{1'b1, 10'h200, 32'hFFFFFFFF, 3'd0, 1'b0, 32'h0,        4'd6},
        '{1'b0, 10'h200, 32'h0,        3'd0, 1'b1, 32'h01010101, 4'd6},  // R6 read-only
        '{1'b1, 10'h208, 32'h02010302, 3'd0, 1'b0, 32'h0,        4'd6},
        '{1'b0, 10'h208, 32'h0,        3'd0, 1'b1, 32'h02010302, 4'd6},  // R6 shared
        '{1'b0, 10'h000, 32'h0,        3'd0, 1'b1, 32'h0,        4'd1},  // R1 reset 0
        '{1'b1, 10'h000, 32'h00000001, 3'd0, 1'b0, 32'h0,        4'd1},
        '{1'b0, 10'h000, 32'h0,        3'd0, 1'b1, 32'h1,        4'd1}   // R1 set
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_cpu(input int c, input logic v, input logic [9:0] id,
                             input logic [7:0] p, input string req);
        check(req, {13'd0, cpu_irq[c], cpu_id[c*10 +: 10], cpu_prio[c*8 +: 8]},
                   {13'd0, v, id, p});
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, input int c);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cpu = CW'(c); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_chk(input logic [9:0] a, input int c, input logic [31:0] exp,
                           input string req);
        @(negedge clk);
        bus_addr = a; bus_cpu = CW'(c); bus_we = 1'b0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (WAIT) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R13: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state, R10 and R1
        check_cpu(0, 1'b0, 10'd1023, 8'hFF, "R10 reset cpu0");
        check_cpu(1, 1'b0, 10'd1023, 8'hFF, "R1 reset cpu1");

        // register table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            bus_addr  = VECS[v].addr;
            bus_wdata = VECS[v].data;
            bus_cpu   = VECS[v].cpu[CW-1:0];
            bus_we    = VECS[v].we;
            #1;
            if (VECS[v].chk) check($sformatf("R%0d vec%0d", VECS[v].req, v), bus_rdata, VECS[v].exp);
        end
        @(negedge clk);
        bus_we = 1'b0;

        // enabled, nothing pending: R10
        settle();
        check_cpu(0, 1'b0, 10'd1023, 8'hFF, "R10 idle cpu0");

        // shared levels with routing: R5 R6 R9
        bus_wr(10'h021, 32'h0000000F, 0);
        @(negedge clk); src_level[3:0] = 4'hF;
        settle();
        check_cpu(0, 1'b1, 10'd34, 8'h22, "R6 route cpu0");
        check_cpu(1, 1'b1, 10'd35, 8'h11, "R5 best cpu1");
        bus_chk(10'h041, 0, 32'h0000000F, "R9 pending word");

        // equal urgency: lower ID wins, R5
        bus_wr(10'h108, 32'h22222222, 0);
        settle();
        check_cpu(0, 1'b1, 10'd33, 8'h22, "R5 tie cpu0");
        check_cpu(1, 1'b1, 10'd32, 8'h22, "R5 tie cpu1");

        // global enable off then on: R1
        bus_wr(10'h000, 32'h0, 0);
        settle();
        check_cpu(0, 1'b0, 10'd1023, 8'hFF, "R1 off cpu0");
        check_cpu(1, 1'b0, 10'd1023, 8'hFF, "R1 off cpu1");
        bus_wr(10'h000, 32'h1, 0);
        settle();
        check_cpu(0, 1'b1, 10'd33, 8'h22, "R13 resume cpu0");

        // acknowledge by cpu0: R11, other CPU unaffected
        bus_wr(10'h002, 32'h0, 0);
        bus_chk(10'h051, 0, 32'h00000002, "R11 active cpu0");
        bus_chk(10'h051, 1, 32'h00000000, "R11 active cpu1");
        settle();
        check_cpu(0, 1'b1, 10'd34, 8'h22, "R11 skip active");
        check_cpu(1, 1'b1, 10'd32, 8'h22, "R11 cpu1 keeps");

        // end of interrupt: R12
        bus_wr(10'h003, 32'd33, 0);
        bus_chk(10'h051, 0, 32'h0, "R12 active cleared");
        settle();
        check_cpu(0, 1'b1, 10'd33, 8'h22, "R12 back");

        // software interrupt to cpu1 only: R8
        bus_wr(10'h020, 32'h00000020, 1);
        bus_wr(10'h004, 32'h00020005, 0);
        bus_chk(10'h040, 1, 32'h00000020, "R8 targeted pending");
        bus_chk(10'h040, 0, 32'h00000000, "R8 untargeted pending");
        settle();
        check_cpu(1, 1'b1, 10'd5, 8'h00, "R8 sgi cpu1");
        check_cpu(0, 1'b1, 10'd33, 8'h22, "R8 cpu0 unchanged");

        // acknowledge of a private ID clears its pending bit: R11
        bus_wr(10'h002, 32'h0, 1);
        bus_chk(10'h040, 1, 32'h00000000, "R11 sgi pending cleared");
        settle();
        check_cpu(1, 1'b1, 10'd32, 8'h22, "R11 cpu1 next");

        // levels dropped: R9
        @(negedge clk); src_level = '0;
        settle();
        check_cpu(0, 1'b0, 10'd1023, 8'hFF, "R9 low cpu0");
        check_cpu(1, 1'b0, 10'd1023, 8'hFF, "R9 low cpu1");
        bus_chk(10'h041, 0, 32'h0, "R9 pending word low");

        // broadcast software interrupt, banked enables differ: R7 R8
        bus_wr(10'h004, 32'h00030002, 1);
        bus_chk(10'h040, 1, 32'h00000004, "R7 cpu1 pending");
        settle();
        check_cpu(0, 1'b1, 10'd2, 8'h00, "R8 broadcast cpu0");
        check_cpu(1, 1'b0, 10'd1023, 8'hFF, "R7 disabled cpu1");

        finish_run();
    end

endmodule